// File: doc/BRIEF.md
# Sequential Block Prefetch Cache

This block sits between a processor's instruction fetch port and a slower main memory. When the processor asks for a word that is not buffered, the block fetches the aligned group of four words holding it in one wide transfer and returns the requested word. While the processor walks through that group, the block fetches the following group, so the stream stays one group ahead.

A request counts as sequential when it names the word right after the last word served. A request that breaks the sequence discards both buffered groups and starts again at the new address. If a fetch is in flight at that moment, its data is thrown away when it returns, and the demand fetch starts after it. The memory port allows one outstanding fetch under a request/acknowledge handshake. The processor holds its request until it receives a one-cycle response pulse. Two counters record hits and misses.

Top module: `prefetch_buf`

## Requirements
- R1: After reset, `cpu_rvalid_o` and `mem_req_o` are low, both counters read zero and no word is buffered, so the first request is a miss.
- R2: A miss fetches line `cpu_addr_i >> 2` over the memory port and returns word `k = addr[1:0]`, taken from `mem_rdata_i[32k+31:32k]` (word 0 is the lowest address). The response comes in the cycle after the acknowledge.
- R3: A sequential request whose word is buffered is a hit. It is answered in the cycle after it is first presented, and the hit counter rises by one.
- R4: Once a group is loaded, the block fetches the next line (base + 1, wrapping at the top of the address space) without waiting for a request. A sequential request that crosses into that line is a hit once the line has arrived.
- R5: A request that is not the successor of the last word served is a miss, even if its word is buffered. It discards both buffers and refetches from its own line.
- R6: After a redirect during an in-flight fetch, the returning data is discarded. The demand fetch is issued afterwards and the correct word is returned.
- R7: A sequential request for the line whose prefetch is still in flight waits for that fetch. No second fetch is issued, and the request counts as a miss.
- R8: `mem_req_o` and `mem_line_o` hold steady until `mem_ack_i`. The request drops in the cycle after the acknowledge, so at most one fetch is outstanding.
- R9: Every served request raises exactly one of the hit and miss counters, never both in the same cycle.
- R10: `cpu_rvalid_o` is a single-cycle pulse for each served request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until the response |
| cpu_addr_i | input | ADDR_W | Word address of the request |
| cpu_rvalid_o | output | 1 | Response pulse |
| cpu_rdata_o | output | DATA_W | Returned word |
| mem_req_o | output | 1 | Memory fetch request |
| mem_line_o | output | ADDR_W-2 | Line address of the fetch |
| mem_ack_i | input | 1 | Fetch acknowledge, data valid in the same cycle |
| mem_rdata_i | input | 4*DATA_W | Four-word line, word 0 in the low bits |
| hit_cnt_o | output | CNT_W | Hit counter |
| miss_cnt_o | output | CNT_W | Miss counter |

## Verification
A hit is due exactly one cycle after the request is first presented. A miss is due one cycle after the memory acknowledge, so its latency follows the memory model's delay. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the moment it raises a request to the moment it sees the response, and it requires a count of one for every hit. Counter deltas, returned data and the log of acknowledged line addresses are read only after the response pulse, when every register on the path has settled.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_CUR,
    SRC_NXT,
    SRC_MEM
  } src_e;
endpackage

// File: rtl/pf_line.sv
module pf_line #(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINE_AW    = 14,
  localparam int LINE_DW   = DATA_W * LINE_WORDS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               ld_i,
  input  logic [LINE_AW-1:0] ld_base_i,
  input  logic [LINE_DW-1:0] ld_data_i,
  output logic               valid_o,
  output logic [LINE_AW-1:0] base_o,
  output logic [LINE_DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      base_o  <= '0;
      data_o  <= '0;
    end else if (ld_i) begin
      valid_o <= 1'b1;
      base_o  <= ld_base_i;
      data_o  <= ld_data_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pf_counter.sv
module pf_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/prefetch_buf.sv
module prefetch_buf
  import pf_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int CNT_W      = 16,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int LINE_AW   = ADDR_W - OFF_W,
  localparam int LINE_DW   = DATA_W * LINE_WORDS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_req_i,
  input  logic [ADDR_W-1:0]  cpu_addr_i,
  output logic               cpu_rvalid_o,
  output logic [DATA_W-1:0]  cpu_rdata_o,
  output logic               mem_req_o,
  output logic [LINE_AW-1:0] mem_line_o,
  input  logic               mem_ack_i,
  input  logic [LINE_DW-1:0] mem_rdata_i,
  output logic [CNT_W-1:0]   hit_cnt_o,
  output logic [CNT_W-1:0]   miss_cnt_o
);
  localparam int NLINES = 2;  // index 0: current line, 1: next line

  logic               ln_clr   [NLINES];
  logic               ln_ld    [NLINES];
  logic [LINE_AW-1:0] ln_ldb   [NLINES];
  logic [LINE_DW-1:0] ln_ldd   [NLINES];
  logic               ln_valid [NLINES];
  logic [LINE_AW-1:0] ln_base  [NLINES];
  logic [LINE_DW-1:0] ln_data  [NLINES];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    pf_line #(
      .DATA_W    (DATA_W),
      .LINE_WORDS(LINE_WORDS),
      .LINE_AW   (LINE_AW)
    ) u_line (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (ln_clr[i]),
      .ld_i     (ln_ld[i]),
      .ld_base_i(ln_ldb[i]),
      .ld_data_i(ln_ldd[i]),
      .valid_o  (ln_valid[i]),
      .base_o   (ln_base[i]),
      .data_o   (ln_data[i])
    );
  end

  logic               busy_q, drop_q, wait_q, exp_v_q, rsp_valid_q;
  logic [ADDR_W-1:0]  wait_addr_q, exp_q;
  logic [LINE_AW-1:0] fetch_line_q;
  logic [DATA_W-1:0]  rsp_data_q;

  logic [LINE_AW-1:0] req_line;
  logic [OFF_W-1:0]   req_off, fill_off;
  logic [ADDR_W-1:0]  fill_addr, serve_addr;
  logic               accept, seq, in_cur, in_nxt;
  logic               hit_cur, hit_nxt, miss, adopt, redirect;
  logic               ack, fill_cur, fill_nxt, issue, serve;
  logic [LINE_AW-1:0] issue_line;
  logic [DATA_W-1:0]  serve_word;
  src_e               src;

  assign req_line = cpu_addr_i[ADDR_W-1:OFF_W];
  assign req_off  = cpu_addr_i[OFF_W-1:0];

  assign accept   = cpu_req_i && !rsp_valid_q && !wait_q;
  assign seq      = exp_v_q && (cpu_addr_i == exp_q);
  assign in_cur   = ln_valid[0] && (ln_base[0] == req_line);
  assign in_nxt   = ln_valid[1] && (ln_base[1] == req_line);
  assign hit_cur  = accept && seq && in_cur;
  assign hit_nxt  = accept && seq && !in_cur && in_nxt;
  assign miss     = accept && !hit_cur && !hit_nxt;
  // sequential miss on the line already in flight: wait for it
  assign adopt    = miss && seq && busy_q && !drop_q && (fetch_line_q == req_line);
  assign redirect = miss && !adopt;

  assign ack       = busy_q && mem_ack_i;
  assign fill_addr = wait_q ? wait_addr_q : cpu_addr_i;
  assign fill_off  = fill_addr[OFF_W-1:0];
  assign fill_cur  = ack && !drop_q &&
                     ((wait_q && fetch_line_q == wait_addr_q[ADDR_W-1:OFF_W]) || adopt);
  assign fill_nxt  = ack && !drop_q && !fill_cur && !redirect;

  assign issue      = !busy_q && !miss && (wait_q || (ln_valid[0] && !ln_valid[1]));
  assign issue_line = wait_q ? wait_addr_q[ADDR_W-1:OFF_W] : ln_base[0] + LINE_AW'(1);

  always_comb begin
    src = SRC_NONE;
    if (fill_cur)     src = SRC_MEM;
    else if (hit_cur) src = SRC_CUR;
    else if (hit_nxt) src = SRC_NXT;
  end

  always_comb begin
    unique case (src)
      SRC_CUR: serve_word = ln_data[0][int'(req_off)*DATA_W +: DATA_W];
      SRC_NXT: serve_word = ln_data[1][int'(req_off)*DATA_W +: DATA_W];
      SRC_MEM: serve_word = mem_rdata_i[int'(fill_off)*DATA_W +: DATA_W];
      default: serve_word = '0;
    endcase
  end

  assign serve      = (src != SRC_NONE);
  assign serve_addr = fill_cur ? fill_addr : cpu_addr_i;

  // current line: refilled by a demand fetch or promoted from next
  assign ln_clr[0] = redirect;
  assign ln_ld[0]  = fill_cur || hit_nxt;
  assign ln_ldb[0] = fill_cur ? fetch_line_q : ln_base[1];
  assign ln_ldd[0] = fill_cur ? mem_rdata_i : ln_data[1];
  assign ln_clr[1] = redirect || hit_nxt;
  assign ln_ld[1]  = fill_nxt;
  assign ln_ldb[1] = fetch_line_q;
  assign ln_ldd[1] = mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      drop_q       <= 1'b0;
      wait_q       <= 1'b0;
      wait_addr_q  <= '0;
      fetch_line_q <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_data_q   <= '0;
      exp_q        <= '0;
      exp_v_q      <= 1'b0;
    end else begin
      rsp_valid_q <= serve;
      if (serve) begin
        rsp_data_q <= serve_word;
        exp_q      <= serve_addr + ADDR_W'(1);
        exp_v_q    <= 1'b1;
      end
      if (issue) begin
        busy_q       <= 1'b1;
        fetch_line_q <= issue_line;
      end else if (ack) begin
        busy_q <= 1'b0;
      end
      if (ack)                    drop_q <= 1'b0;
      else if (redirect && busy_q) drop_q <= 1'b1;
      if (miss && !fill_cur) begin
        wait_q      <= 1'b1;
        wait_addr_q <= cpu_addr_i;
      end else if (fill_cur) begin
        wait_q <= 1'b0;
      end
    end
  end

  pf_counter #(.W(CNT_W)) u_hit_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (hit_cur || hit_nxt),
    .cnt_o (hit_cnt_o)
  );

  pf_counter #(.W(CNT_W)) u_miss_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (miss),
    .cnt_o (miss_cnt_o)
  );

  assign cpu_rvalid_o = rsp_valid_q;
  assign cpu_rdata_o  = rsp_data_q;
  assign mem_req_o    = busy_q;
  assign mem_line_o   = fetch_line_q;
endmodule

// File: rtl/prefetch_buf_chk.sv
module prefetch_buf_chk #(
  parameter int LINE_AW = 14,
  parameter int CNT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cpu_rvalid_o,
  input logic               mem_req_o,
  input logic [LINE_AW-1:0] mem_line_o,
  input logic               mem_ack_i,
  input logic [CNT_W-1:0]   hit_cnt_o,
  input logic [CNT_W-1:0]   miss_cnt_o
);
  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_line_o));

  // R8
  req_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o);

  // R10
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rvalid_o |=> !cpu_rvalid_o);

  // R9
  single_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hit_cnt_o) |-> $stable(miss_cnt_o));

  // R3
  hit_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hit_cnt_o) |-> cpu_rvalid_o);
endmodule

bind prefetch_buf prefetch_buf_chk #(
  .LINE_AW(LINE_AW),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_rvalid_o(cpu_rvalid_o),
  .mem_req_o   (mem_req_o),
  .mem_line_o  (mem_line_o),
  .mem_ack_i   (mem_ack_i),
  .hit_cnt_o   (hit_cnt_o),
  .miss_cnt_o  (miss_cnt_o)
);

// File: tb/prefetch_buf_bench.sv
module prefetch_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  // {expect_hit, address}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 16'h0100}, {1'b1, 16'h0101}, {1'b1, 16'h0102}, {1'b1, 16'h0103},
    {1'b1, 16'h0104}, {1'b1, 16'h0105}, {1'b1, 16'h0106}, {1'b1, 16'h0107},
    {1'b0, 16'h0200}, {1'b1, 16'h0201}, {1'b1, 16'h0202}, {1'b1, 16'h0203},
    {1'b1, 16'h0204}, {1'b0, 16'h030A}, {1'b1, 16'h030B}, {1'b1, 16'h030C},
    {1'b1, 16'h030D}, {1'b0, 16'h030D}, {1'b1, 16'h030E}, {1'b1, 16'h030F},
    {1'b1, 16'h0310}, {1'b0, 16'h030F}, {1'b0, 16'hFFFE}, {1'b1, 16'hFFFF},
    {1'b1, 16'h0000}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cpu_req_i = 1'b0;
  logic [15:0]  cpu_addr_i = '0;
  logic         cpu_rvalid_o;
  logic [31:0]  cpu_rdata_o;
  logic         mem_req_o;
  logic [13:0]  mem_line_o;
  logic         mem_ack_i = 1'b0;
  logic [127:0] mem_rdata_i = '0;
  logic [15:0]  hit_cnt_o, miss_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  int mem_lat = 2;
  int ack_n = 0;
  logic [13:0] ack_log [64];
  int last_lat = 0;

  prefetch_buf u_prefetch_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_rvalid_o(cpu_rvalid_o),
    .cpu_rdata_o (cpu_rdata_o),
    .mem_req_o   (mem_req_o),
    .mem_line_o  (mem_line_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .hit_cnt_o   (hit_cnt_o),
    .miss_cnt_o  (miss_cnt_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] word_of(input logic [15:0] a);
    return {~a, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: acknowledge after mem_lat sampled cycles of request
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk_i);
      mem_ack_i = 1'b0;
      if (mem_req_o && rst_ni) begin
        cnt++;
        if (cnt >= mem_lat) begin
          for (int k = 0; k < 4; k++)
            mem_rdata_i[k*32 +: 32] = word_of({mem_line_o, 2'(k)});
          mem_ack_i = 1'b1;
          if (ack_n < 64) ack_log[ack_n] = mem_line_o;
          ack_n++;
          cnt = 0;
        end
      end else begin
        cnt = 0;
      end
    end
  end

  // call at a falling edge; returns at a falling edge after one idle cycle
  task automatic access(input logic [15:0] a, input bit exp_hit, input string tag);
    logic [15:0] h0, m0;
    int cyc;
    h0 = hit_cnt_o;
    m0 = miss_cnt_o;
    cpu_addr_i = a;
    cpu_req_i = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk_i);
      cyc++;
    end while (!cpu_rvalid_o && cyc < 400);
    last_lat = cyc;
    chk(cpu_rvalid_o, tag, 32'(cyc), 32'd0);
    chk(cpu_rdata_o == word_of(a), tag, cpu_rdata_o, word_of(a));
    // R9: exactly one counter moves per request
    if (exp_hit) begin
      chk(hit_cnt_o == h0 + 16'd1 && miss_cnt_o == m0, {tag, " R9 hit count"},
          {hit_cnt_o, miss_cnt_o}, {h0 + 16'd1, m0});
      chk(cyc == 1, {tag, " R3 hit latency"}, 32'(cyc), 32'd1);
    end else begin
      chk(miss_cnt_o == m0 + 16'd1 && hit_cnt_o == h0, {tag, " R9 miss count"},
          {hit_cnt_o, miss_cnt_o}, {h0, m0 + 16'd1});
    end
    cpu_req_i = 1'b0;
    @(negedge clk_i);
    chk(!cpu_rvalid_o, "R10 pulse width", 32'(cpu_rvalid_o), 32'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a0;
    idle(3);
    // R1: reset state
    chk(!cpu_rvalid_o && !mem_req_o, "R1 outputs idle", {cpu_rvalid_o, mem_req_o}, 0);
    chk(hit_cnt_o == 0 && miss_cnt_o == 0, "R1 counters", {hit_cnt_o, miss_cnt_o}, 0);
    rst_ni = 1'b1;
    idle(2);
    chk(!mem_req_o, "R1 no fetch without request", 32'(mem_req_o), 0);

    // table walk: sequential runs, jumps, repeats, wrap
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][15:0], VEC[i][16], VEC[i][16] ? "R3/R4 table" : "R2/R5 table");
      if (i == 0)
        chk(ack_n >= 1 && ack_log[0] == 14'h040, "R2 line address",
            32'(ack_log[0]), 32'h40);
      if (i == 3)
        chk(ack_n >= 2 && ack_log[1] == 14'h041, "R4 prefetch ahead",
            32'(ack_log[1]), 32'h41);
    end

    // R7: sequential request while its prefetch is in flight
    idle(20);
    mem_lat = 12;
    access(16'h0400, 1'b0, "R7 setup");
    access(16'h0401, 1'b1, "R7 setup");
    access(16'h0402, 1'b1, "R7 setup");
    access(16'h0403, 1'b1, "R7 setup");
    a0 = ack_n;
    access(16'h0404, 1'b0, "R7 wait on prefetch");
    chk(ack_n == a0 + 1 && ack_log[a0] == 14'h101, "R7 single fetch",
        32'(ack_n - a0), 32'd1);
    chk(last_lat > 1, "R7 stalled", 32'(last_lat), 32'd2);

    // R6: redirect while a prefetch is in flight
    idle(30);
    access(16'h0500, 1'b0, "R6 setup");
    access(16'h0501, 1'b1, "R6 setup");
    a0 = ack_n;
    access(16'h0800, 1'b0, "R6 redirect");
    chk(ack_n == a0 + 2, "R6 fetch count", 32'(ack_n - a0), 32'd2);
    chk(ack_log[a0] == 14'h141 && ack_log[a0+1] == 14'h200, "R6 drop then demand",
        {ack_log[a0], ack_log[a0+1]}, {14'h141, 14'h200});
    access(16'h0801, 1'b1, "R6 after redirect");
    access(16'h0802, 1'b1, "R6 after redirect");
    access(16'h0803, 1'b1, "R6 after redirect");
    access(16'h0804, 1'b0, "R6 next line not stale");

    // R5: buffered but non-sequential word is still a miss
    idle(30);
    mem_lat = 1;
    access(16'h0805, 1'b1, "R5 setup");
    access(16'h0805, 1'b0, "R5 repeat word");
    access(16'h0804, 1'b0, "R5 backward");

    // R8: request held until acknowledge
    idle(10);
    mem_lat = 5;
    cpu_addr_i = 16'h0A00;
    cpu_req_i = 1'b1;
    idle(3);
    chk(mem_req_o && mem_line_o == 14'h280, "R8 request held",
        {mem_req_o, mem_line_o}, {1'b1, 14'h280});
    while (!cpu_rvalid_o) @(negedge clk_i);
    chk(cpu_rdata_o == word_of(16'h0A00), "R8 data", cpu_rdata_o, word_of(16'h0A00));
    cpu_req_i = 1'b0;
    idle(20);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule